// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block lets synchronous logic read and write an asynchronous static RAM with an 8-bit data bus. The host presents an address, a write flag, write data and a request. When the sequencer is idle it signals ready, takes the request, runs one complete memory access and then pulses done. For a read, the captured byte appears on the read-data output in the same cycle as done.

On the memory side the sequencer drives the address, an active-low select, an active-high select, an active-low output enable and an active-low write strobe. It shares a bidirectional data bus with the memory. Every phase of an access lasts a whole number of clock cycles, and these counts are parameters, so the sequencer can meet the memory's minimum read and write times at any clock period. The defaults suit an 8 ns clock.

Writes are strobe-controlled and keep output enable low for the whole strobe. The memory may still be driving the bus for a short time after the strobe falls, so the sequencer waits a set number of cycles before it drives the write data. It runs only one access at a time.

Top module: `sram_ctl`

## Requirements
- R1: During and right after reset the block drives the following: ready is 1, done is 0, the active-low select is 1, the active-high select is 0, output enable is 1, the write strobe is 1, and the controller does not drive the data bus.
- R2: An accepted read asserts both selects and output enable, with the write strobe high, for RD_CYCLES cycles. The address stays stable for all of those cycles. The data bus is sampled on the last of these edges. The byte then appears on rsp_rdata, and done is high for exactly one cycle, RD_CYCLES+1 cycles after acceptance.
- R3: Read timing: the bus is sampled no sooner than 70 ns after the address and selects last changed. It is also sampled no sooner than 35 ns after output enable fell. The select stays active for at least 70 ns.
- R4: An accepted write holds the write strobe low for exactly WE_CYCLES cycles, with both selects active and output enable low. The strobe lasts at least 55 ns, and the address is set up at least 60 ns before the strobe rises.
- R5: Write data is driven from DQ_DELAY cycles after the strobe falls and does not change until the controller releases the bus. This gives the data at least 30 ns of setup before the strobe rises.
- R6: After the write strobe rises, the address and selects hold for one more cycle with output enable high. The bus is released after that cycle. Done pulses WE_CYCLES+2 cycles after acceptance.
- R7: The controller drives the data bus only when the write strobe is low or output enable is high, so it never contends with a memory that is driving the bus.
- R8: Ready is high only while idle. A request held high during an access is ignored: it changes no memory location and does not extend the access.
- R9: A write cycle, measured from the select going active to it going inactive, lasts at least 70 ns.
- R10: Across a random mix of reads and writes at random addresses, every read returns the byte most recently written to that address, or 0 if the address has never been written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Idle, request taken this cycle |
| rsp_done | output | 1 | One-cycle pulse at access end |
| rsp_rdata | output | 8 | Byte captured by the last read |
| mem_addr | output | ADDR_W | Memory address |
| mem_ce_n | output | 1 | Active-low memory select |
| mem_ce2 | output | 1 | Active-high memory select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_dq | inout | 8 | Shared data bus |

## Verification
On every cycle, the assertions check four things:
- the bus is never driven while the memory may be driving it;
- the write strobe is never low unless both selects are active and output enable is low;
- the strobe stays low for exactly the configured count, and one hold cycle with selects active and output enable high follows before done;
- the driven write byte stays steady.

The nanosecond limits can only be shown by the bench's memory model, which times every edge: address and data setup, strobe width, read access and cycle times. The same applies to read-after-write integrity and to requests ignored while busy, which the bench shows by reading the memory back through the block.

// File: rtl/sram_ctl.sv
`timescale 1ns/1ps
module sram_ctl #(
  parameter int ADDR_W    = 10,
  parameter int RD_CYCLES = 9,
  parameter int WE_CYCLES = 8,
  parameter int DQ_DELAY  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_wdata,
  output logic              req_ready,
  output logic              rsp_done,
  output logic [7:0]        rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_ce2,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  inout  wire  [7:0]        mem_dq
);
  localparam int MAXC  = (RD_CYCLES > WE_CYCLES) ? RD_CYCLES : WE_CYCLES;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] RD_LAST = CNT_W'(RD_CYCLES - 1);
  localparam logic [CNT_W-1:0] WE_LAST = CNT_W'(WE_CYCLES - 1);
  localparam logic [CNT_W-1:0] DQ_ON   = CNT_W'(DQ_DELAY - 1);

  typedef enum logic [1:0] {S_IDLE, S_READ, S_WRITE, S_HOLD} state_t;

  state_t           state;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       wdat;
  logic             dq_oe;

  assign req_ready = (state == S_IDLE);
  assign mem_dq    = dq_oe ? wdat : 8'bz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      wdat      <= '0;
      dq_oe     <= 1'b0;
      rsp_done  <= 1'b0;
      rsp_rdata <= '0;
      mem_addr  <= '0;
      mem_ce_n  <= 1'b1;
      mem_ce2   <= 1'b0;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
    end else begin
      rsp_done <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          mem_addr <= req_addr;
          wdat     <= req_wdata;
          cnt      <= '0;
          mem_ce_n <= 1'b0;
          mem_ce2  <= 1'b1;
          mem_oe_n <= 1'b0;
          if (req_write) begin
            mem_we_n <= 1'b0;
            state    <= S_WRITE;
          end else begin
            state    <= S_READ;
          end
        end
        S_READ: begin
          if (cnt == RD_LAST) begin
            rsp_rdata <= mem_dq;
            rsp_done  <= 1'b1;
            mem_ce_n  <= 1'b1;
            mem_ce2   <= 1'b0;
            mem_oe_n  <= 1'b1;
            state     <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_WRITE: begin
          cnt <= cnt + 1'b1;
          if (cnt == DQ_ON) dq_oe <= 1'b1;
          if (cnt == WE_LAST) begin
            mem_we_n <= 1'b1;
            mem_oe_n <= 1'b1;
            state    <= S_HOLD;
          end
        end
        default: begin
          dq_oe    <= 1'b0;
          mem_ce_n <= 1'b1;
          mem_ce2  <= 1'b0;
          rsp_done <= 1'b1;
          state    <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/sram_ctl_chk.sv
`timescale 1ns/1ps
module sram_ctl_chk #(
  parameter int ADDR_W    = 10,
  parameter int WE_CYCLES = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_done,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_ce2,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [7:0]        mem_dq,
  input logic              dq_oe
);
  logic [15:0] we_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         we_low <= '0;
    else if (!mem_we_n) we_low <= we_low + 16'd1;
    else                we_low <= '0;
  end

  a_r7_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (!mem_we_n || mem_oe_n));

  a_r4_write_selected: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_ce2 && !mem_oe_n));

  a_r4_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_low == 16'(WE_CYCLES)));

  a_r6_hold_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (!mem_ce_n && mem_ce2 && mem_oe_n && dq_oe && !req_ready));

  a_r6_done_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |=> (rsp_done && !dq_oe && mem_ce_n && $stable(mem_addr)));

  a_r5_data_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && $past(dq_oe)) |-> $stable(mem_dq));

  a_r8_idle_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n && !dq_oe));

  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
endmodule

bind sram_ctl sram_ctl_chk #(.ADDR_W(ADDR_W), .WE_CYCLES(WE_CYCLES)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_done(rsp_done),
  .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_ce2(mem_ce2),
  .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq(mem_dq), .dq_oe(dq_oe)
);

// File: tb/sram_ctl_tb_top.sv
`timescale 1ns/1ps
module sram_ctl_tb_top;
  localparam int AW = 10;
  localparam int RDC = 9;
  localparam int WEC = 8;
  localparam int DQD = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, rsp_done;
  logic [7:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic mem_ce_n, mem_ce2, mem_oe_n, mem_we_n;
  wire [7:0] mem_dq;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sram_ctl #(.ADDR_W(AW), .RD_CYCLES(RDC), .WE_CYCLES(WEC), .DQ_DELAY(DQD)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_ce2(mem_ce2), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dq(mem_dq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // memory model
  logic [7:0] mem_m [DEPTH];
  logic [7:0] ref_m [DEPTH];
  realtime t_sel = 0, t_oe = 0, t_wef = 0, t_dq = 0, t_cef = 0;
  bit m_valid = 0, was_wr = 0;
  wire sel = !mem_ce_n && mem_ce2;
  wire m_drive = sel && !mem_oe_n && mem_we_n;
  wire [7:0] m_out = m_valid ? mem_m[mem_addr] : ~mem_m[mem_addr];
  assign mem_dq = m_drive ? m_out : 8'bz;

  initial for (int i = 0; i < DEPTH; i++) begin mem_m[i] = 8'h00; ref_m[i] = 8'h00; end

  always @(mem_addr or mem_ce_n or mem_ce2) begin t_sel = $realtime; m_valid = 0; end
  always @(negedge mem_oe_n) begin t_oe = $realtime; m_valid = 0; end
  always @(negedge mem_ce_n) t_cef = $realtime;
  always @(negedge mem_we_n) begin t_wef = $realtime; was_wr = 1; end
  always @(mem_dq) if (!mem_we_n) t_dq = $realtime;
  always begin
    #1;
    m_valid = (($realtime - t_sel) >= 70.0) && (($realtime - t_oe) >= 35.0);
  end

  always @(posedge mem_we_n) if (rst_n && sel) begin
    check(($realtime - t_wef) >= 55.0, "R4 strobe ns", int'($realtime - t_wef), 55);
    check(($realtime - t_sel) >= 60.0, "R4 addr setup ns", int'($realtime - t_sel), 60);
    check(($realtime - t_dq) >= 30.0, "R5 data setup ns", int'($realtime - t_dq), 30);
    mem_m[mem_addr] = mem_dq;
  end

  always @(posedge mem_ce_n) if (rst_n) begin
    if (was_wr) check(($realtime - t_cef) >= 70.0, "R9 write cycle ns", int'($realtime - t_cef), 70);
    else        check(($realtime - t_cef) >= 70.0, "R3 read cycle ns", int'($realtime - t_cef), 70);
    was_wr = 0;
  end

  // one access; called and returns at a negedge with ready high
  task automatic access(input bit wr, input logic [AW-1:0] a, input logic [7:0] d,
                        input bit junk, output logic [7:0] q);
    int n;
    bit bad;
    int exp_lat;
    exp_lat = wr ? WEC + 2 : RDC + 1;
    bad = 0;
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    if (junk) begin
      req_write = 1; req_addr = a ^ AW'(1); req_wdata = ~d;
    end else req_valid = 0;
    n = 1;
    while (!rsp_done && n < 64) begin
      if (req_ready || mem_addr != a || mem_ce_n || !mem_ce2) bad = 1;
      if (wr) begin
        if (n <= WEC && (mem_we_n || mem_oe_n)) bad = 1;
        if (n == WEC + 1 && (!mem_we_n || !mem_oe_n)) bad = 1;
      end else if (mem_oe_n || !mem_we_n) bad = 1;
      n++;
      @(negedge clk);
    end
    req_valid = 0;
    if (wr) check(!bad, "R4 R6 write pins", int'(bad), 0);
    else    check(!bad, "R2 read pins", int'(bad), 0);
    check(n == exp_lat, wr ? "R6 write latency" : "R2 read latency", n, exp_lat);
    if (junk) check(!bad, "R8 ready low while busy", int'(bad), 0);
    check(req_ready && mem_ce_n && mem_oe_n && mem_we_n, "R2 idle after done",
          int'({req_ready, mem_ce_n, mem_oe_n, mem_we_n}), 15);
    q = rsp_rdata;
    if (wr) ref_m[a] = d;
  endtask

  task automatic rd_check(input logic [AW-1:0] a, input string req);
    logic [7:0] q;
    access(0, a, 8'h00, 0, q);
    check(q === ref_m[a], req, int'(q), int'(ref_m[a]));
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] q;
    void'($urandom(32'd12345));
    repeat (3) @(negedge clk);
    check(req_ready && !rsp_done && mem_ce_n && !mem_ce2 && mem_oe_n && mem_we_n,
          "R1 reset pins", int'({req_ready, rsp_done, mem_ce_n, mem_ce2, mem_oe_n, mem_we_n}), 6'b101011);
    rst_n = 1;
    @(negedge clk);
    check(req_ready && mem_ce_n && mem_we_n, "R1 after reset",
          int'({req_ready, mem_ce_n, mem_we_n}), 7);

    access(1, 10'h000, 8'hA5, 0, q);
    rd_check(10'h000, "R2 read back first");
    access(1, 10'h3FF, 8'hFF, 0, q);
    rd_check(10'h3FF, "R2 read top address");
    access(1, 10'h3FF, 8'h00, 0, q);
    rd_check(10'h3FF, "R10 overwrite zero");
    access(1, 10'h155, 8'h5A, 0, q);
    access(1, 10'h2AA, 8'hC3, 0, q);
    rd_check(10'h155, "R10 alternate pattern a");
    rd_check(10'h2AA, "R10 alternate pattern b");

    access(1, 10'h040, 8'h3C, 1, q);
    rd_check(10'h041, "R8 junk request ignored");
    access(0, 10'h040, 8'h00, 1, q);
    check(q === ref_m[10'h040], "R8 read with held request", int'(q), int'(ref_m[10'h040]));
    rd_check(10'h041, "R8 junk write not performed");

    for (int i = 0; i < 300; i++) begin
      logic [AW-1:0] a;
      logic [7:0] d;
      a = AW'($urandom_range(0, DEPTH - 1));
      d = 8'($urandom);
      if ($urandom_range(0, 1) == 1) access(1, a, d, 0, q);
      else rd_check(a, "R10 random read");
    end
    for (int i = 0; i < 16; i++) rd_check(AW'(i * 64 + 3), "R10 sweep read");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule